// File: doc/BRIEF.md
# Byte Arithmetic and Logic Unit with Condition Flags

This block is the combinational datapath of an accumulator-style 8-bit processor. Each cycle it takes an operation code, the accumulator, the X index register, an operand byte and the incoming condition flags. It returns the result byte, the next flag vector, a per-flag write mask and a code that tells the surrounding core where the result belongs. Instruction decode, register storage, memory access and decimal arithmetic stay outside the block.

The unit covers data movement, the three bitwise operations, add with carry, and subtract with an inverted borrow. It also covers compares against the accumulator or against X, a bit test, increment and decrement, the four shift and rotate forms, and a fused operation that subtracts the operand from (A AND X) and sends the result to X. One adder serves every arithmetic form. Flags that an operation does not touch pass through unchanged, and the mask reports which flags were written.

Top module: `byte_alu`

## Requirements
- R1: op_sel codes are 0 pass operand, 1 AND, 2 OR, 3 XOR. The flag vector bits are C=0, Z=1, V=2 and N=3. Pass and the three logic codes produce operand, acc AND operand, acc OR operand and acc XOR operand, and they write only Z (result is zero) and N (result bit 7).
- R2: Code 4 adds: result = acc + operand + C modulo 256. C becomes bit 8 of the sum. V is set when acc and operand agree in sign and the result's sign differs from acc's.
- R3: Code 5 subtracts: result = acc − operand − (1 − C) modulo 256. C becomes 1 when no borrow occurred. V is set when acc differs in sign from both the operand and the result.
- R4: Code 6 compares acc with the operand and code 7 compares X with the operand. res_out is the low byte of register − operand. Z and N come from that byte, C = (register ≥ operand) as unsigned values, and V is left alone.
- R5: Code 8 is the bit test. res_out = acc AND operand, Z is set when that is zero, N = operand bit 7, V = operand bit 6, and C is left alone.
- R6: Code 11 shifts the operand left with bit 7 going to C. Code 12 shifts it right with bit 0 going to C, and N is always 0 afterwards.
- R7: Code 13 rotates left with the old C entering bit 0 and bit 7 leaving into C. Code 14 rotates right with the old C entering bit 7 and bit 0 leaving into C.
- R8: Code 15 computes (acc AND X) − operand modulo 256. Z, N and C are set as a compare would set them, and V is left alone.
- R9: Code 9 increments and code 10 decrements the operand modulo 256. Only Z and N are written, and C is unaffected even on wrap.
- R10: flag_we has a 1 exactly for each flag the operation writes. Every flag with flag_we 0 appears on flags_out with its incoming value.
- R11: res_dest is 0 when the result is discarded (codes 6, 7, 8), 2 when it belongs in X (code 15), and 1 otherwise.
- R12: All outputs are a combinational function of the present inputs, with no state and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator value |
| xr_in | input | 8 | X register value |
| opnd_in | input | 8 | Operand byte |
| flags_in | input | 4 | Incoming flags {N,V,Z,C} |
| res_out | output | 8 | Result byte |
| flags_out | output | 4 | Next flags {N,V,Z,C} |
| flag_we | output | 4 | Flags written by this operation |
| res_dest | output | 2 | Result destination code |

## Verification
Every result and flag is due in the same cycle as its stimulus, because no register lies between inputs and outputs. The bench changes inputs 1 ns after a rising clock edge and compares all four outputs at the next falling edge, which gives the logic half a period to settle. The sweep walks all sixteen codes over a grid of accumulator and operand values with both carry states, and it adds directed overflow, wrap and equality corners.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

  localparam int OP_W   = 4;
  localparam int FLAG_N = 4;

  // flag vector bit positions
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FV = 2;
  localparam int FN = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS    = 4'd0,
    OP_AND     = 4'd1,
    OP_OR      = 4'd2,
    OP_XOR     = 4'd3,
    OP_ADC     = 4'd4,
    OP_SBC     = 4'd5,
    OP_CMPA    = 4'd6,
    OP_CMPX    = 4'd7,
    OP_BITT    = 4'd8,
    OP_INC     = 4'd9,
    OP_DEC     = 4'd10,
    OP_SHL     = 4'd11,
    OP_SHR     = 4'd12,
    OP_ROTL    = 4'd13,
    OP_ROTR    = 4'd14,
    OP_ANDXSUB = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_MAIN = 2'd1,
    DST_X    = 2'd2
  } alu_dst_e;

  // per-operation flag write mask {N,V,Z,C}
  function automatic logic [FLAG_N-1:0] flag_mask(input alu_op_e o);
    logic [FLAG_N-1:0] m;
    m = '0;
    unique case (o)
      OP_ADC, OP_SBC:                         m = 4'b1111;
      OP_CMPA, OP_CMPX, OP_ANDXSUB,
      OP_SHL, OP_SHR, OP_ROTL, OP_ROTR:       m = 4'b1011;
      OP_BITT:                                m = 4'b1110;
      default:                                m = 4'b1010;
    endcase
    return m;
  endfunction

  function automatic alu_dst_e dest_of(input alu_op_e o);
    alu_dst_e d;
    unique case (o)
      OP_CMPA, OP_CMPX, OP_BITT: d = DST_NONE;
      OP_ANDXSUB:                d = DST_X;
      default:                   d = DST_MAIN;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// One ripple adder shared by add, subtract, compare, inc/dec and the fused op.
// Subtraction is a + ~b + cin, so carry out means "no borrow".
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cin,
  input  logic              inv_b,
  output logic [DATA_W-1:0] sum_out,
  output logic              cout,
  output logic              ovf
);

  localparam int SUM_W = DATA_W + 1;

  function automatic logic [SUM_W-1:0] wide_add(
    input logic [DATA_W-1:0] x,
    input logic [DATA_W-1:0] y,
    input logic              c
  );
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c};
  endfunction

  function automatic logic sign_ovf(
    input logic xs,
    input logic ys,
    input logic rs
  );
    // operands agree in sign, result disagrees
    return ~(xs ^ ys) & (xs ^ rs);
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic [SUM_W-1:0]  total;

  assign b_eff   = inv_b ? ~b_in : b_in;
  assign total   = wide_add(a_in, b_eff, cin);
  assign sum_out = total[DATA_W-1:0];
  assign cout    = total[DATA_W];
  assign ovf     = sign_ovf(a_in[DATA_W-1], b_eff[DATA_W-1], total[DATA_W-1]);

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] res
);

  always_comb begin
    unique case (op)
      OP_AND, OP_BITT: res = a_in & b_in;
      OP_OR:           res = a_in | b_in;
      OP_XOR:          res = a_in ^ b_in;
      default:         res = b_in;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] v_in,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  function automatic logic [DATA_W:0] go_left(input logic [DATA_W-1:0] v, input logic fill);
    return {v, fill};
  endfunction

  function automatic logic [DATA_W:0] go_right(input logic [DATA_W-1:0] v, input logic fill);
    return {fill, v};
  endfunction

  logic [DATA_W:0] lft, rgt;
  logic            fill_bit;

  assign fill_bit = (op == OP_ROTL || op == OP_ROTR) ? cin : 1'b0;
  assign lft      = go_left(v_in, fill_bit);
  assign rgt      = go_right(v_in, fill_bit);

  always_comb begin
    if (op == OP_SHL || op == OP_ROTL) begin
      res  = lft[DATA_W-1:0];
      cout = lft[DATA_W];
    end else begin
      res  = rgt[DATA_W:1];
      cout = rgt[0];
    end
  end

endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] xr_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [FLAG_N-1:0] flags_in,
  output logic [DATA_W-1:0] res_out,
  output logic [FLAG_N-1:0] flags_out,
  output logic [FLAG_N-1:0] flag_we,
  output logic [1:0]        res_dest
);

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // adder operand steering
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_inv, add_carry, add_ovf;

  always_comb begin
    add_a   = acc_in;
    add_b   = opnd_in;
    add_cin = 1'b0;
    add_inv = 1'b0;
    unique case (op)
      OP_ADC:     add_cin = flags_in[FC];
      OP_SBC:     begin add_cin = flags_in[FC]; add_inv = 1'b1; end
      OP_CMPA:    begin add_cin = 1'b1; add_inv = 1'b1; end
      OP_CMPX:    begin add_a = xr_in; add_cin = 1'b1; add_inv = 1'b1; end
      OP_ANDXSUB: begin add_a = acc_in & xr_in; add_cin = 1'b1; add_inv = 1'b1; end
      OP_INC:     begin add_a = opnd_in; add_b = '0; add_cin = 1'b1; end
      OP_DEC:     begin add_a = opnd_in; add_b = '0; add_inv = 1'b1; end
      default:    ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) u_add (
    .a_in    (add_a),
    .b_in    (add_b),
    .cin     (add_cin),
    .inv_b   (add_inv),
    .sum_out (add_sum),
    .cout    (add_carry),
    .ovf     (add_ovf)
  );

  logic [DATA_W-1:0] log_res;
  alu_logic #(.DATA_W(DATA_W)) u_log (
    .op   (op),
    .a_in (acc_in),
    .b_in (opnd_in),
    .res  (log_res)
  );

  logic [DATA_W-1:0] sh_res;
  logic              sh_carry;
  alu_shift #(.DATA_W(DATA_W)) u_sh (
    .op   (op),
    .v_in (opnd_in),
    .cin  (flags_in[FC]),
    .res  (sh_res),
    .cout (sh_carry)
  );

  // result select and candidate flags
  logic [DATA_W-1:0] res_sel;
  logic [FLAG_N-1:0] flag_new;
  logic              uses_add, uses_sh;

  assign uses_add = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMPA) ||
                    (op == OP_CMPX) || (op == OP_ANDXSUB) || (op == OP_INC) ||
                    (op == OP_DEC);
  assign uses_sh  = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROTL) ||
                    (op == OP_ROTR);

  always_comb begin
    if (uses_add)     res_sel = add_sum;
    else if (uses_sh) res_sel = sh_res;
    else              res_sel = log_res;
  end

  always_comb begin
    flag_new[FZ] = (res_sel == '0);
    flag_new[FN] = res_sel[DATA_W-1];
    flag_new[FC] = uses_sh ? sh_carry : add_carry;
    flag_new[FV] = add_ovf;
    if (op == OP_BITT) begin
      flag_new[FN] = opnd_in[DATA_W-1];
      flag_new[FV] = opnd_in[DATA_W-2];
    end
  end

  logic [FLAG_N-1:0] mask;
  assign mask = flag_mask(op);

  // per-flag merge: written flags take the new value, others pass through
  for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_merge
    assign flags_out[gi] = mask[gi] ? flag_new[gi] : flags_in[gi];
  end

  assign res_out  = res_sel;
  assign flag_we  = mask;
  assign res_dest = dest_of(op);

endmodule

// File: rtl/byte_alu_chk.sv
`timescale 1ns/1ps
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] xr_in,
  input logic [DATA_W-1:0] opnd_in,
  input logic [FLAG_N-1:0] flags_in,
  input logic [DATA_W-1:0] res_out,
  input logic [FLAG_N-1:0] flags_out,
  input logic [FLAG_N-1:0] flag_we,
  input logic [1:0]        res_dest
);

  logic known;
  assign known = !$isunknown({op_sel, acc_in, xr_in, opnd_in, flags_in});

  always_comb begin
    if (known) begin
      p_zero_tracks_r1: assert (!flag_we[FZ] || (flags_out[FZ] == (res_out == '0)))
        else $error("Z disagrees with result");
      p_sub_borrow_r3: assert (!(op_sel == OP_SBC && flags_in[FC]) ||
                               (flags_out[FC] == (acc_in >= opnd_in)))
        else $error("subtract carry wrong");
      p_cmp_carry_r4: assert (op_sel != OP_CMPA || (flags_out[FC] == (acc_in >= opnd_in)))
        else $error("compare carry wrong");
      p_bit_copy_r5: assert (op_sel != OP_BITT ||
                             (flags_out[FN] == opnd_in[DATA_W-1] &&
                              flags_out[FV] == opnd_in[DATA_W-2]))
        else $error("bit test copy wrong");
      p_shr_neg_r6: assert (op_sel != OP_SHR || !flags_out[FN])
        else $error("right shift set N");
      p_axs_dest_r8: assert (op_sel != OP_ANDXSUB || res_dest == DST_X)
        else $error("fused op not routed to X");
      p_incdec_carry_r9: assert (!(op_sel == OP_INC || op_sel == OP_DEC) ||
                                 flags_out[FC] == flags_in[FC])
        else $error("inc/dec touched carry");
      p_keep_unwritten_r10: assert (((flags_out ^ flags_in) & ~flag_we) == '0)
        else $error("unwritten flag changed");
    end
  end

endmodule

bind byte_alu byte_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_sel    (op_sel),
  .acc_in    (acc_in),
  .xr_in     (xr_in),
  .opnd_in   (opnd_in),
  .flags_in  (flags_in),
  .res_out   (res_out),
  .flags_out (flags_out),
  .flag_we   (flag_we),
  .res_dest  (res_dest)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [3:0] op_sel   = 4'd0;
  logic [7:0] acc_in   = 8'd0;
  logic [7:0] xr_in    = 8'd0;
  logic [7:0] opnd_in  = 8'd0;
  logic [3:0] flags_in = 4'd0;
  logic [7:0] res_out;
  logic [3:0] flags_out;
  logic [3:0] flag_we;
  logic [1:0] res_dest;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  byte_alu u0 (
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .xr_in     (xr_in),
    .opnd_in   (opnd_in),
    .flags_in  (flags_in),
    .res_out   (res_out),
    .flags_out (flags_out),
    .flag_we   (flag_we),
    .res_dest  (res_dest)
  );

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2, 3: return "R1";
      4:          return "R2";
      5:          return "R3";
      6, 7:       return "R4";
      8:          return "R5";
      11, 12:     return "R6";
      13, 14:     return "R7";
      15:         return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // independent arithmetic model, integer based
  task automatic model(input int op, input int a, input int x, input int m, input int fin,
                       output int r, output int fout, output int we, output int dst);
    int c, s, sv, cn, vn, nn;
    c = fin % 2; cn = 0; vn = 0; r = 0; we = 10; dst = 1;
    case (op)
      0: r = m;
      1: r = a & m;
      2: r = a | m;
      3: r = a ^ m;
      4: begin s = a + m + c; r = s % 256; cn = (s > 255);
               sv = sgn(a) + sgn(m) + c; vn = (sv > 127 || sv < -128); we = 15; end
      5: begin s = a - m - (1 - c); r = (s + 512) % 256; cn = (s >= 0);
               sv = sgn(a) - sgn(m) - (1 - c); vn = (sv > 127 || sv < -128); we = 15; end
      6: begin r = (a - m + 256) % 256; cn = (a >= m); we = 11; dst = 0; end
      7: begin r = (x - m + 256) % 256; cn = (x >= m); we = 11; dst = 0; end
      8: begin r = a & m; vn = (m / 64) % 2; we = 14; dst = 0; end
      9: r = (m + 1) % 256;
      10: r = (m + 255) % 256;
      11: begin r = (m * 2) % 256; cn = m / 128; we = 11; end
      12: begin r = m / 2; cn = m % 2; we = 11; end
      13: begin r = (m * 2) % 256 + c; cn = m / 128; we = 11; end
      14: begin r = m / 2 + 128 * c; cn = m % 2; we = 11; end
      default: begin r = ((a & x) - m + 256) % 256; cn = ((a & x) >= m); we = 11; dst = 2; end
    endcase
    nn = (op == 8) ? (m / 128) : (r / 128);
    fout = 0;
    fout += ((we / 1) % 2) ? cn : (fin / 1) % 2;
    fout += 2 * (((we / 2) % 2) ? int'(r == 0) : (fin / 2) % 2);
    fout += 4 * (((we / 4) % 2) ? vn : (fin / 4) % 2);
    fout += 8 * (((we / 8) % 2) ? nn : (fin / 8) % 2);
  endtask

  // R12: outputs are combinational; drive 1 ns after rise, sample at the fall
  task automatic run_vec(input int op, input int a, input int x, input int m, input int fin);
    int er, ef, ew, ed;
    @(posedge clk); #1;
    op_sel = op[3:0]; acc_in = a[7:0]; xr_in = x[7:0]; opnd_in = m[7:0]; flags_in = fin[3:0];
    model(op, a, x, m, fin, er, ef, ew, ed);
    @(negedge clk);
    checks++;
    if (res_out != er[7:0] || flags_out != ef[3:0]) begin
      failures++;
      $display("FAIL %s op=%0d a=%02h x=%02h m=%02h f=%01h: res/flags %02h/%01h expected %02h/%01h",
               req_of(op), op, a, x, m, fin, res_out, flags_out, er, ef);
    end
    checks++;
    if (flag_we != ew[3:0]) begin
      failures++;
      $display("FAIL R10 op=%0d: flag_we %01h expected %01h", op, flag_we, ew);
    end
    checks++;
    if (res_dest != ed[1:0]) begin
      failures++;
      $display("FAIL R11 op=%0d: res_dest %0d expected %0d", op, res_dest, ed);
    end
  endtask

  initial begin
    // idle state check, R1: pass of zero sets Z only
    @(negedge clk);
    checks++;
    if (res_out != 8'h00 || flags_out != 4'b0010) begin
      failures++;
      $display("FAIL R1 idle: res/flags %02h/%01h expected 00/2", res_out, flags_out);
    end

    // directed corners
    run_vec(4, 8'h7F, 0, 8'h01, 0);      // R2 signed overflow
    run_vec(4, 8'hFF, 0, 8'h00, 1);      // R2 carry out, zero
    run_vec(5, 8'h80, 0, 8'h01, 1);      // R3 overflow, no borrow
    run_vec(5, 8'h00, 0, 8'h00, 0);      // R3 borrow in -> FF
    run_vec(6, 8'h42, 0, 8'h42, 4);      // R4 equal, V held
    run_vec(7, 0, 8'h10, 8'h11, 1);      // R4 X below operand
    run_vec(8, 8'h0F, 0, 8'hC0, 1);      // R5 zero AND, copies
    run_vec(9, 0, 0, 8'hFF, 1);          // R9 wrap up, C held
    run_vec(10, 0, 0, 8'h00, 0);         // R9 wrap down
    run_vec(12, 0, 0, 8'h01, 8);         // R6 to zero, N cleared
    run_vec(11, 0, 0, 8'h80, 0);         // R6 carry out
    run_vec(14, 0, 0, 8'h01, 1);         // R7 carry into bit 7
    run_vec(13, 0, 0, 8'h80, 1);         // R7 carry into bit 0
    run_vec(15, 8'hF0, 8'h3C, 8'h31, 0); // R8 borrow
    run_vec(15, 8'hFF, 8'h55, 8'h55, 0); // R8 equal
    run_vec(2, 8'h00, 0, 8'hFF, 5);      // R1 N set, C/V kept

    // grid sweep over every code
    for (int op = 0; op < 16; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a += 5)
          for (int m = 0; m < 256; m += 7)
            run_vec(op, a, (a * 3 + 8'h5A) % 256, m, ci ? 5 : 10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R12 watchdog: run still busy, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule